// File: doc/BRIEF.md
# Pipelined Sample Threshold Screener

This block decides, for every incoming ADC sample, whether the sample lies strictly above a programmable threshold. It is built for a fast sample clock, 250 MHz in the target system. The comparison is a subtraction of the sample from the threshold, widened so that its most significant position is the sign. The carry of that subtraction is never allowed to travel the full width in one cycle. The operands are split into equal slices. Each slice adds in its own register stage, and the carry between slices is held in a flip-flop. Only the final carry, which is the inverse of the sign of the widened difference, forms the pass decision. A sample that crosses the threshold near mid-range therefore always gets a clean, fully registered answer, with no cycle where the sign is unsettled.

Samples enter on a valid/ready stream and leave on a second valid/ready stream. Each sample goes out together with its pass flag, and its value is unchanged. The threshold is a plain input. It is captured together with each accepted sample, so it may change on any cycle and only affects the samples accepted from then on. Back-pressure is global: the input is ready exactly when the output is ready, and a low output ready freezes every stage. A sample is accepted on a rising edge where `s_valid` and `s_ready` are both high. An output beat is taken on a rising edge where `m_valid` and `m_ready` are both high. While `m_valid` is high and `m_ready` is low, the output beat does not change.

Top module: `thrscr_top`

## Requirements
- R1: For every output beat, `m_pass` is 1 exactly when the sample is greater than the threshold that was presented with it, both read as unsigned numbers. A sample equal to its threshold gives `m_pass` = 0.
- R2: While `m_ready` stays high, a sample accepted on rising edge n appears on `m_valid`/`m_sample`/`m_pass` after rising edge n+LATENCY-1, where LATENCY = CARRY_STAGES + 3 (6 by default). The sample value comes out unchanged.
- R3: One sample is accepted on every clock while `m_ready` is high. A run of back-to-back samples leaves as a run of back-to-back output beats with no gaps, in the same order.
- R4: The threshold is taken on the same edge as its sample. A change of `s_thresh` affects only samples accepted on or after the edge where it is first present. Samples already in flight keep the threshold they were accepted with.
- R5: `s_ready` equals `m_ready`. On an edge where `m_ready` is low, no sample is accepted, and `m_valid`, `m_sample` and `m_pass` keep their values.
- R6: An active-high synchronous reset clears every valid and pass flag. After a reset edge, `m_valid` and `m_pass` read 0 and stay 0 until a sample accepted after the reset reaches the output.
- R7: `m_pass` is never 1 while `m_valid` is 0.
- R8: A cycle with `s_valid` low creates no output beat, whatever values `s_sample` and `s_thresh` carry in that cycle.
- R9: The decision is correct at the extremes of the 10-bit range and at the mid-range crossing. Sample/threshold pairs 0/0, 1023/0, 0/1023, 1023/1023, 512/511, 511/512 and 512/512 give pass values 0, 1, 0, 0, 1, 0, 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock; all state changes on its rising edge |
| rst | input | 1 | Active-high synchronous reset |
| s_valid | input | 1 | Input sample present |
| s_ready | output | 1 | Input may be accepted; equal to `m_ready` |
| s_sample | input | SAMPLE_W | Unsigned sample value |
| s_thresh | input | SAMPLE_W | Unsigned threshold, taken with each accepted sample |
| m_valid | output | 1 | Output beat present |
| m_ready | input | 1 | Downstream can take a beat; low stalls the whole pipeline |
| m_sample | output | SAMPLE_W | Sample value, delayed to line up with its decision |
| m_pass | output | 1 | Sample exceeded its threshold |

## Verification
The bound checker keeps its own delay line of the input handshakes and of a plain greater-than result. On every cycle it checks that `m_valid` and `m_pass` match that delay line. It also checks that `m_pass` implies `m_valid`, that a stalled output holds still, and that a reset edge empties the output. What the assertions cannot show is how the block behaves over whole patterns of traffic. The bench's scenarios cover these: the exact first-beat latency from an empty pipeline, the gap-free run of a long burst, thresholds that change on every cycle under samples already in flight, the corner pairs at the range edges and at mid-range, and a reset that arrives with a full pipeline.

// File: rtl/thrscr_pkg.sv
package thrscr_pkg;

  // Default sample width and number of carry-split register stages.
  parameter int unsigned SAMPLE_W_DEF     = 10;
  parameter int unsigned CARRY_STAGES_DEF = 3;

  // Fixed register stages around the carry chain: two in front, one behind.
  parameter int unsigned FRONT_REGS = 2;
  parameter int unsigned BACK_REGS  = 1;

  // Width of one operand slice. The difference is one bit wider than the
  // sample, and that extended width is shared out across the stages.
  function automatic int unsigned seg_width(int unsigned sample_w,
                                            int unsigned stages);
    return (sample_w + 1 + stages - 1) / stages;
  endfunction

endpackage

// File: rtl/thrscr_stage_reg.sv
// One pipeline register carrying a data word and its valid flag.
// Only the flag is reset; the data word is don't-care while the flag is low.
module thrscr_stage_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (en) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      out_data <= in_data;
    end
  end

endmodule

// File: rtl/thrscr_skew.sv
// Operand skew line. It delays one operand slice by DEPTH enabled clocks,
// so the slice meets the carry coming out of the stage below it.
module thrscr_skew #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk,
  input  logic         en,
  input  logic [W-1:0] in_data,
  output logic [W-1:0] out_data
);

  logic [W-1:0] dly [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      dly[0] <= in_data;
      for (int i = 1; i < DEPTH; i++) begin
        dly[i] <= dly[i-1];
      end
    end
  end

  assign out_data = dly[DEPTH-1];

endmodule

// File: rtl/thrscr_carry_stage.sv
// One slice of the split subtraction. It ripples the carry across SEG_W bits
// and registers only the carry-out. The sample and its valid flag travel
// alongside so they stay aligned with the decision.
module thrscr_carry_stage #(
  parameter int unsigned SEG_W    = 4,
  parameter int unsigned SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic [SEG_W-1:0]    in_a,
  input  logic [SEG_W-1:0]    in_b,
  input  logic                in_carry,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_sample,
  output logic                out_carry
);

  function automatic logic ripple_carry(input logic [SEG_W-1:0] a,
                                        input logic [SEG_W-1:0] b,
                                        input logic             cin);
    logic c;
    c = cin;
    for (int i = 0; i < SEG_W; i++) begin
      c = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
    end
    return c;
  endfunction

  logic carry_nxt;

  always_comb begin
    carry_nxt = ripple_carry(in_a, in_b, in_carry);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (en) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (en) begin
      out_sample <= in_sample;
      out_carry  <= carry_nxt;
    end
  end

endmodule

// File: rtl/thrscr_top.sv
// Threshold screener: pass = (sample > threshold), decided from the borrow of
// the widened difference threshold - sample. The carry is cut into
// CARRY_STAGES registered slices.
module thrscr_top
  import thrscr_pkg::*;
#(
  parameter int unsigned SAMPLE_W     = SAMPLE_W_DEF,
  parameter int unsigned CARRY_STAGES = CARRY_STAGES_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_sample,
  input  logic [SAMPLE_W-1:0] s_thresh,
  output logic                m_valid,
  input  logic                m_ready,
  output logic [SAMPLE_W-1:0] m_sample,
  output logic                m_pass
);

  localparam int unsigned SEG_W   = seg_width(SAMPLE_W, CARRY_STAGES);
  localparam int unsigned PAD_W   = SEG_W * CARRY_STAGES;
  localparam int unsigned ZPAD_W  = PAD_W - SAMPLE_W;
  localparam int unsigned PAIR_W  = 2 * SAMPLE_W;
  localparam int unsigned LATENCY = FRONT_REGS + CARRY_STAGES + BACK_REGS;

  // Global advance: every stage moves when the consumer can take a beat.
  logic adv;
  assign adv     = m_ready;
  assign s_ready = m_ready;

  // Front registers: input boundary plus the screening-entry stage.
  logic [FRONT_REGS:0] ent_v;
  logic [PAIR_W-1:0]   ent_d [FRONT_REGS+1];

  assign ent_v[0] = s_valid;
  assign ent_d[0] = {s_thresh, s_sample};

  for (genvar g = 0; g < FRONT_REGS; g++) begin : g_front
    thrscr_stage_reg #(.DATA_W(PAIR_W)) u_front (
      .clk      (clk),
      .rst      (rst),
      .en       (adv),
      .in_valid (ent_v[g]),
      .in_data  (ent_d[g]),
      .out_valid(ent_v[g+1]),
      .out_data (ent_d[g+1])
    );
  end

  logic [SAMPLE_W-1:0] ent_thr;
  logic [SAMPLE_W-1:0] ent_smp;
  assign {ent_thr, ent_smp} = ent_d[FRONT_REGS];

  // threshold + ~sample + 1 over PAD_W bits; carry-out 1 means no borrow.
  logic [PAD_W-1:0] opnd_a;
  logic [PAD_W-1:0] opnd_b;
  assign opnd_a = {{ZPAD_W{1'b0}}, ent_thr};
  assign opnd_b = ~{{ZPAD_W{1'b0}}, ent_smp};

  // Slice j waits j clocks so it meets the carry from slice j-1.
  logic [SEG_W-1:0] sl_a [CARRY_STAGES];
  logic [SEG_W-1:0] sl_b [CARRY_STAGES];

  for (genvar j = 0; j < CARRY_STAGES; j++) begin : g_slice
    if (j == 0) begin : g_direct
      assign sl_a[j] = opnd_a[SEG_W-1:0];
      assign sl_b[j] = opnd_b[SEG_W-1:0];
    end else begin : g_skewed
      logic [2*SEG_W-1:0] sk_out;
      thrscr_skew #(.W(2*SEG_W), .DEPTH(j)) u_skew (
        .clk     (clk),
        .en      (adv),
        .in_data ({opnd_a[j*SEG_W +: SEG_W], opnd_b[j*SEG_W +: SEG_W]}),
        .out_data(sk_out)
      );
      assign sl_a[j] = sk_out[2*SEG_W-1:SEG_W];
      assign sl_b[j] = sk_out[SEG_W-1:0];
    end
  end

  // Carry chain, one registered slice per stage.
  logic [CARRY_STAGES:0] ch_v;
  logic [CARRY_STAGES:0] ch_c;
  logic [SAMPLE_W-1:0]   ch_s [CARRY_STAGES+1];

  assign ch_v[0] = ent_v[FRONT_REGS];
  assign ch_c[0] = 1'b1;
  assign ch_s[0] = ent_smp;

  for (genvar k = 0; k < CARRY_STAGES; k++) begin : g_carry
    thrscr_carry_stage #(.SEG_W(SEG_W), .SAMPLE_W(SAMPLE_W)) u_stage (
      .clk       (clk),
      .rst       (rst),
      .en        (adv),
      .in_valid  (ch_v[k]),
      .in_sample (ch_s[k]),
      .in_a      (sl_a[k]),
      .in_b      (sl_b[k]),
      .in_carry  (ch_c[k]),
      .out_valid (ch_v[k+1]),
      .out_sample(ch_s[k+1]),
      .out_carry (ch_c[k+1])
    );
  end

  // Output register: a borrow (no final carry) means sample > threshold.
  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_pass  <= 1'b0;
    end else if (adv) begin
      m_valid <= ch_v[CARRY_STAGES];
      m_pass  <= ch_v[CARRY_STAGES] & ~ch_c[CARRY_STAGES];
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      m_sample <= ch_s[CARRY_STAGES];
    end
  end

  // The total stage count must match the advertised latency.
  initial begin
    if (LATENCY != CARRY_STAGES + 3) begin
      $error("stage count does not match latency");
    end
  end

endmodule

// File: rtl/thrscr_chk.sv
// Checker bound to thrscr_top. It keeps its own delay line of accepted
// beats and of a plain greater-than result, advanced by the handshake.
module thrscr_chk #(
  parameter int unsigned SAMPLE_W     = 10,
  parameter int unsigned CARRY_STAGES = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                s_valid,
  input logic [SAMPLE_W-1:0] s_sample,
  input logic [SAMPLE_W-1:0] s_thresh,
  input logic                m_valid,
  input logic                m_ready,
  input logic                m_pass,
  input logic [SAMPLE_W-1:0] m_sample
);

  localparam int unsigned LAT = CARRY_STAGES + 3;

  logic [LAT-1:0] ref_v;
  logic [LAT-1:0] ref_p;
  logic           rst_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_v <= '0;
      ref_p <= '0;
    end else if (m_ready) begin
      ref_v <= {ref_v[LAT-2:0], s_valid};
      ref_p <= {ref_p[LAT-2:0], s_valid && (s_sample > s_thresh)};
    end
  end

  // R6
  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) begin
      reset_clear_chk: assert (!m_valid && !m_pass)
        else $error("output flags not cleared after reset");
    end
  end

  // R2
  valid_ref_chk: assert property (@(posedge clk) disable iff (rst)
    m_valid == ref_v[LAT-1])
    else $error("output valid out of step with accepted beats");

  // R1
  pass_ref_chk: assert property (@(posedge clk) disable iff (rst)
    m_pass == ref_p[LAT-1])
    else $error("pass flag differs from greater-than result");

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !m_ready |=> ($stable(m_valid) && $stable(m_pass) && $stable(m_sample)))
    else $error("output changed during stall");

  // R7
  pass_valid_chk: assert property (@(posedge clk) disable iff (rst)
    m_pass |-> m_valid)
    else $error("pass flag without valid");

endmodule

bind thrscr_top thrscr_chk #(
  .SAMPLE_W    (SAMPLE_W),
  .CARRY_STAGES(CARRY_STAGES)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .s_valid (s_valid),
  .s_sample(s_sample),
  .s_thresh(s_thresh),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_pass  (m_pass),
  .m_sample(m_sample)
);

// File: tb/thrscr_top_tb.sv
`timescale 1ns/1ps
module thrscr_top_tb;

  localparam int  SW         = 10;
  localparam int  CS         = 3;
  localparam int  LAT        = CS + 3;
  localparam time CLK_PERIOD = 4ns;
  localparam int  MAXV       = (1 << SW) - 1;

  logic          clk;
  logic          rst;
  logic          s_valid;
  logic          s_ready;
  logic [SW-1:0] s_sample;
  logic [SW-1:0] s_thresh;
  logic          m_valid;
  logic          m_ready;
  logic [SW-1:0] m_sample;
  logic          m_pass;

  thrscr_top #(.SAMPLE_W(SW), .CARRY_STAGES(CS)) u_dut (
    .clk     (clk),
    .rst     (rst),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .s_sample(s_sample),
    .s_thresh(s_thresh),
    .m_valid (m_valid),
    .m_ready (m_ready),
    .m_sample(m_sample),
    .m_pass  (m_pass)
  );

  typedef struct {
    bit          v;
    bit [SW-1:0] s;
    bit          p;
    int          r;
  } ent_t;

  ent_t q[$];
  int   n_cmp     = 0;
  int   n_bad     = 0;
  int   cur_req   = 6;
  int   out_beats = 0;
  bit   done      = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: a queue of the last LAT accepted slots.
  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      for (int i = 0; i < LAT; i++) q.push_back('{v: 1'b0, s: '0, p: 1'b0, r: 6});
    end else if (m_ready) begin
      ent_t e;
      e.v = s_valid;
      e.s = s_sample;
      e.p = s_valid && (s_sample > s_thresh);
      e.r = cur_req;
      q.push_back(e);
      if (q.size() > LAT) void'(q.pop_front());
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Wait for a falling edge and compare every output with the model.
  task automatic step();
    @(negedge clk);
    chk(s_ready == m_ready, "R5", "s_ready", int'(s_ready), int'(m_ready));
    if (m_valid && m_ready) out_beats++;
    if (q.size() > 0) begin
      ent_t e;
      string tag;
      e   = q[0];
      tag = $sformatf("R%0d", e.r);
      chk(m_valid == e.v, tag, "m_valid", int'(m_valid), int'(e.v));
      if (e.v) begin
        chk(m_sample == e.s, tag, "m_sample", int'(m_sample), int'(e.s));
        chk(m_pass == e.p, tag, "m_pass", int'(m_pass), int'(e.p));
      end else begin
        chk(m_pass == 1'b0, "R7", "m_pass while invalid", int'(m_pass), 0);
      end
    end
  endtask

  task automatic drv(input bit v, input int s, input int t, input int req);
    s_valid  = v;
    s_sample = s[SW-1:0];
    s_thresh = t[SW-1:0];
    cur_req  = req;
    step();
  endtask

  task automatic idle(input int n, input int req);
    for (int i = 0; i < n; i++) drv(1'b0, 0, 0, req);
  endtask

  initial begin
    int first;
    bit saw_valid;
    logic [SW-1:0] hold_s;
    logic hold_v, hold_p;

    rst = 1'b1; m_ready = 1'b1; s_valid = 1'b0; s_sample = '0; s_thresh = '0;
    repeat (3) step();
    // R6: reset state
    chk(!m_valid && !m_pass, "R6", "reset flags", int'({m_valid, m_pass}), 0);
    rst = 1'b0;
    idle(2, 6);

    // R2: first-beat latency from an empty pipeline
    first = 0;
    s_valid = 1'b1; s_sample = 10'd700; s_thresh = 10'd100; cur_req = 2;
    for (int k = 1; k <= LAT + 3; k++) begin
      step();
      if (k == 1) s_valid = 1'b0;
      if (m_valid && first == 0) first = k;
    end
    chk(first == LAT, "R2", "latency", first, LAT);

    // R9: range ends and mid-range crossing, back to back
    drv(1, 0, 0, 9);       drv(1, MAXV, 0, 9);   drv(1, 0, MAXV, 9);
    drv(1, MAXV, MAXV, 9); drv(1, 512, 511, 9);  drv(1, 511, 512, 9);
    drv(1, 512, 512, 9);
    idle(LAT, 9);

    // R1: equal and neighbouring values
    for (int i = 0; i < 60; i++) begin
      int s = $urandom_range(1, MAXV - 1);
      int d = $urandom_range(0, 2) - 1;
      drv(1, s, s + d, 1);
    end
    idle(LAT, 1);

    // R3: gap-free burst
    out_beats = 0;
    for (int i = 0; i < 30; i++) drv(1, $urandom_range(0, MAXV), $urandom_range(0, MAXV), 3);
    idle(LAT + 2, 3);
    chk(out_beats == 30, "R3", "burst beats", out_beats, 30);

    // R4: threshold changing every cycle under a fixed sample
    for (int i = 0; i < 30; i++) drv(1, 400, 399 + (i % 3), 4);
    idle(LAT, 4);

    // R8: junk on invalid cycles produces nothing
    idle(LAT, 8);
    saw_valid = 0;
    for (int i = 0; i < 20; i++) begin
      drv(0, $urandom_range(0, MAXV), $urandom_range(0, MAXV), 8);
      if (m_valid) saw_valid = 1;
    end
    chk(saw_valid == 0, "R8", "beats from invalid input", int'(saw_valid), 0);
    for (int i = 0; i < 40; i++)
      drv($urandom_range(0, 1) == 1, $urandom_range(0, MAXV), $urandom_range(0, MAXV), 8);
    idle(LAT, 8);

    // R5: a held stall keeps the output still
    for (int i = 0; i < LAT; i++) drv(1, 900 - i, 300, 5);
    hold_v = m_valid; hold_s = m_sample; hold_p = m_pass;
    m_ready = 1'b0;
    for (int i = 0; i < 5; i++) begin
      drv(1, $urandom_range(0, MAXV), $urandom_range(0, MAXV), 5);
      chk(m_valid == hold_v && m_sample == hold_s && m_pass == hold_p, "R5",
          "stall hold sample", int'(m_sample), int'(hold_s));
    end
    m_ready = 1'b1;
    for (int i = 0; i < 80; i++) begin
      m_ready = ($urandom_range(0, 3) != 0);
      drv($urandom_range(0, 3) != 0, $urandom_range(0, MAXV), $urandom_range(0, MAXV), 5);
    end
    m_ready = 1'b1;
    idle(LAT, 5);

    // R6: reset with a full pipeline
    for (int i = 0; i < LAT; i++) drv(1, 1000, 5, 6);
    rst = 1'b1;
    drv(1, 1000, 5, 6);
    rst = 1'b0;
    chk(!m_valid && !m_pass, "R6", "flags after mid-run reset", int'({m_valid, m_pass}), 0);
    idle(LAT + 1, 6);

    // R1: random bulk
    for (int i = 0; i < 2000; i++)
      drv($urandom_range(0, 7) != 0, $urandom_range(0, MAXV), $urandom_range(0, MAXV), 1);
    idle(LAT + 2, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R3 watchdog: actual=%0d expected=%0d", 100000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule